// File: doc/BRIEF.md
# Post-Access Status Check Sequencer

This block sits between a requester and a frame generator that talks to a remote register responder. The requester hands over one register access: a command word, a read or write flag, and 64-bit write data. The sequencer sends that access to the frame generator. If the access succeeds, it reads the responder's status register and tests its error flag. When the flag is set, it reads two diagnostic registers and then writes zero to the status, error and diagnostic-log registers to clear them. It then reports one of three outcomes.

The block holds `busy` high for the whole sequence and refuses new requests during that time. An access and its status check therefore always run as one unit that nothing can interrupt. The frame generator owns bus timing and framing. This block only issues one transfer at a time: a one-cycle `xf_start`, then a wait for `xf_done` with a pass or fail indication and the 64-bit reply.

Top module: `status_check_seq`

## Requirements
- R1: A request is taken when `req_valid` is high and `busy` is low. The first transfer then carries the requester's command, write flag and, for a write, its write data.
- R2: After the requested transfer succeeds, the next transfer is a read with command 0x60002 (status).
- R3: When the status read succeeds and status bit 61 is 0, the access ends with `result` = 0 (ok) and no further transfer is issued. Other status bits, such as 60 and 62, have no effect.
- R4: When status bit 61 is 1, the block reads command 0x60004 (error register) and then command 0x60008 (log register).
- R5: After the two diagnostic reads, the block issues three write transfers with all-zero data, in the order 0x60002, 0x60004, 0x60008.
- R6: A failure reported for any diagnostic read or clearing write does not stop the sequence. The access ends with `result` = 2 (remote error).
- R7: If the requested transfer or the status read reports failure, the access ends at once with `result` = 1 (link error), and no further transfer is issued.
- R8: The reply data of a successful requested read, status read, error read and log read each appears on its own output (`rd_data`, `status_word`, `error_word`, `log_word`). Each value is held until the next request is taken, which clears all four to zero. A failed transfer leaves its output at zero.
- R9: `busy` rises in the cycle after a request is taken and falls in the cycle in which `done` pulses for one cycle. A request raised while `busy` is high is ignored.
- R10: `xf_start` is a one-cycle pulse, issued only while `busy` is high, and never again until the previous transfer's `xf_done` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_cmd | input | 32 | Command word of the access |
| req_wdata | input | 64 | Write data of the access |
| busy | output | 1 | Sequence in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 link error, 2 remote error |
| rd_data | output | 64 | Reply of the requested read |
| status_word | output | 64 | Captured status register |
| error_word | output | 64 | Captured error register |
| log_word | output | 64 | Captured log register |
| xf_start | output | 1 | Transfer launch pulse to the frame generator |
| xf_write | output | 1 | Transfer direction |
| xf_cmd | output | 32 | Transfer command word |
| xf_wdata | output | 64 | Transfer write data |
| xf_done | input | 1 | Transfer finished |
| xf_fail | input | 1 | Transfer failed (with `xf_done`) |
| xf_rdata | input | 64 | Transfer reply data (with `xf_done`) |

## Verification
Faults in the step counter or the phase register show up at the frame-generator port on the very next `xf_start`. The symptom is a command that is wrong, missing or out of order, a read issued where a write belongs, or a transfer that should never have been launched. A bad capture select puts a reply word on the wrong output within one cycle of `xf_done`. A wrong decision on the error flag or on a failure produces the wrong `result`, and the wrong number of transfers, at the `done` pulse that closes the same access.

// File: rtl/ssc_pkg.sv
// Shared types for the status check sequencer.
// Assumes: step order is the order transfers are issued in.
package ssc_pkg;
    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_LINK   = 2'd1,
        RES_REMOTE = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        ST_MAIN  = 3'd0,
        ST_STAT  = 3'd1,
        ST_ERRRD = 3'd2,
        ST_LOGRD = 3'd3,
        ST_CLRS  = 3'd4,
        ST_CLRE  = 3'd5,
        ST_CLRL  = 3'd6
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;
endpackage

// File: rtl/ssc_step_table.sv
// Maps the current step to the transfer fields sent to the frame generator.
// Assumes: the latched request fields are stable for the whole sequence.
module ssc_step_table
    import ssc_pkg::*;
#(
    parameter int CMD_W = 32,
    parameter int DATA_W = 64,
    parameter logic [CMD_W-1:0] STAT_CMD = 32'h0006_0002,
    parameter logic [CMD_W-1:0] ERR_CMD  = 32'h0006_0004,
    parameter logic [CMD_W-1:0] LOG_CMD  = 32'h0006_0008
) (
    input  step_e             step,
    input  logic [CMD_W-1:0]  main_cmd,
    input  logic              main_write,
    input  logic [DATA_W-1:0] main_wdata,
    output logic [CMD_W-1:0]  cmd,
    output logic              write,
    output logic [DATA_W-1:0] wdata
);
    // Select command, direction and data for the step.
    always_comb begin
        cmd   = main_cmd;
        write = main_write;
        wdata = '0;
        unique case (step)
            ST_MAIN: begin
                if (main_write) wdata = main_wdata;
            end
            ST_STAT:  begin cmd = STAT_CMD; write = 1'b0; end
            ST_ERRRD: begin cmd = ERR_CMD;  write = 1'b0; end
            ST_LOGRD: begin cmd = LOG_CMD;  write = 1'b0; end
            ST_CLRS:  begin cmd = STAT_CMD; write = 1'b1; end
            ST_CLRE:  begin cmd = ERR_CMD;  write = 1'b1; end
            ST_CLRL:  begin cmd = LOG_CMD;  write = 1'b1; end
            default:  begin cmd = main_cmd; write = main_write; end
        endcase
    end
endmodule

// File: rtl/ssc_capture.sv
// Holds the reply words of the requested read, status, error and log reads.
// Assumes: a slot is loaded only on a successful transfer of its own step;
// every slot clears when a new request is taken.
module ssc_capture
    import ssc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NSLOT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  step_e             step,
    input  logic              main_write,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] slot [NSLOT]
);
    generate
        for (genvar k = 0; k < NSLOT; k++) begin : g_slot
            logic hit;
            // Slot 0 is the requested read; slots 1..3 follow the step number.
            if (k == 0) begin : g_main
                assign hit = (step == ST_MAIN) && !main_write;
            end else begin : g_diag
                assign hit = (step == step_e'(k));
            end
            // Clear on a new access, load on a successful matching reply.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) slot[k] <= '0;
                else if (load && hit) slot[k] <= rdata;
            end
        end
    endgenerate
endmodule

// File: rtl/ssc_ctrl.sv
// Phase and step control: launches one transfer at a time and decides
// the next step from the failure flag and the status error flag.
// Assumes: xf_done arrives only while a transfer is outstanding.
module ssc_ctrl
    import ssc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    xf_done,
    input  logic    xf_fail,
    input  logic    err_flag,
    output logic    accept,
    output logic    busy,
    output logic    issue,
    output logic    load,
    output step_e   step,
    output logic    done,
    output result_e result
);
    phase_e phase;

    assign accept = (phase == PH_IDLE) && req_valid;
    assign busy   = (phase != PH_IDLE);
    assign issue  = (phase == PH_ISSUE);
    assign load   = (phase == PH_WAIT) && xf_done && !xf_fail;

    // Advance phase and step; raise done with the outcome at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            step   <= ST_MAIN;
            done   <= 1'b0;
            result <= RES_OK;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (req_valid) begin
                    phase <= PH_ISSUE;
                    step  <= ST_MAIN;
                end
                PH_ISSUE: phase <= PH_WAIT;
                PH_WAIT: if (xf_done) begin
                    if ((step == ST_MAIN || step == ST_STAT) && xf_fail) begin
                        phase <= PH_IDLE; done <= 1'b1; result <= RES_LINK;
                    end else if (step == ST_STAT && !err_flag) begin
                        phase <= PH_IDLE; done <= 1'b1; result <= RES_OK;
                    end else if (step == ST_CLRL) begin
                        phase <= PH_IDLE; done <= 1'b1; result <= RES_REMOTE;
                    end else begin
                        phase <= PH_ISSUE;
                        step  <= step_e'(step + 3'd1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    a_r10_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);
    a_r7_link_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && xf_done && xf_fail && step <= ST_STAT)
        |=> (done && result == RES_LINK && !busy));
    a_r3_clean_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && xf_done && !xf_fail && step == ST_STAT && !err_flag)
        |=> (done && result == RES_OK));
    a_r6_remote_end: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && xf_done && step == ST_CLRL)
        |=> (done && result == RES_REMOTE));
endmodule

// File: rtl/status_check_seq.sv
// Top of the post-access status check sequencer. Latches the request,
// drives the frame-generator request from the step table, and exposes
// the captured reply words.
// Assumes: one frame generator, one transfer outstanding at a time.
module status_check_seq
    import ssc_pkg::*;
#(
    parameter int CMD_W = 32,
    parameter int DATA_W = 64,
    parameter int ERR_BIT = 61,
    parameter logic [CMD_W-1:0] STAT_CMD = 32'h0006_0002,
    parameter logic [CMD_W-1:0] ERR_CMD  = 32'h0006_0004,
    parameter logic [CMD_W-1:0] LOG_CMD  = 32'h0006_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] error_word,
    output logic [DATA_W-1:0] log_word,
    output logic              xf_start,
    output logic              xf_write,
    output logic [CMD_W-1:0]  xf_cmd,
    output logic [DATA_W-1:0] xf_wdata,
    input  logic              xf_done,
    input  logic              xf_fail,
    input  logic [DATA_W-1:0] xf_rdata
);
    localparam int NSLOT = 4;

    logic              accept, load;
    step_e             step;
    result_e           res;
    logic [CMD_W-1:0]  m_cmd;
    logic              m_write;
    logic [DATA_W-1:0] m_wdata;
    logic [DATA_W-1:0] slot [NSLOT];

    // Latch the requested access when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cmd <= '0; m_write <= 1'b0; m_wdata <= '0;
        end else if (accept) begin
            m_cmd <= req_cmd; m_write <= req_write; m_wdata <= req_wdata;
        end
    end

    ssc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .xf_done(xf_done), .xf_fail(xf_fail), .err_flag(xf_rdata[ERR_BIT]),
        .accept(accept), .busy(busy), .issue(xf_start), .load(load),
        .step(step), .done(done), .result(res)
    );

    ssc_step_table #(
        .CMD_W(CMD_W), .DATA_W(DATA_W),
        .STAT_CMD(STAT_CMD), .ERR_CMD(ERR_CMD), .LOG_CMD(LOG_CMD)
    ) u_table (
        .step(step), .main_cmd(m_cmd), .main_write(m_write), .main_wdata(m_wdata),
        .cmd(xf_cmd), .write(xf_write), .wdata(xf_wdata)
    );

    ssc_capture #(.DATA_W(DATA_W), .NSLOT(NSLOT)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept), .load(load), .step(step),
        .main_write(m_write), .rdata(xf_rdata), .slot(slot)
    );

    assign result      = res;
    assign rd_data     = slot[0];
    assign status_word = slot[1];
    assign error_word  = slot[2];
    assign log_word    = slot[3];

    a_r10_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        xf_start |-> busy);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !done) |=> (xf_cmd == $past(xf_cmd) || xf_start || $past(xf_start) || $past(xf_done)));
endmodule

// File: tb/status_check_seq_bench.sv
// Sweeps write/read, failure position and status error flag; a bench
// responder model answers transfers and logs what was issued.
module status_check_seq_bench;
    localparam logic [31:0] C_STAT = 32'h0006_0002;
    localparam logic [31:0] C_ERR  = 32'h0006_0004;
    localparam logic [31:0] C_LOG  = 32'h0006_0008;
    localparam logic [63:0] V_STAT = 64'h5000_00AB_CDEF_1234; // bits 62,60 set
    localparam logic [63:0] V_ERR  = 64'h0E0E_1111_2222_3333;
    localparam logic [63:0] V_LOG  = 64'h0101_4444_5555_6666;
    localparam logic [63:0] V_MAIN = 64'hA5A5_0F0F_C3C3_9696;
    localparam int LAT = 3;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [31:0] req_cmd = 0;
    logic [63:0] req_wdata = 0;
    logic busy, done, xf_start, xf_write;
    logic [1:0] result;
    logic [63:0] rd_data, status_word, error_word, log_word, xf_wdata;
    logic [31:0] xf_cmd;
    logic xf_done = 0, xf_fail = 0;
    logic [63:0] xf_rdata = 0;

    int checks = 0, failures = 0;
    int nops;
    logic [31:0] lc [8];
    logic        lw [8];
    logic [63:0] ld [8];
    int fail_at = 7;
    logic err_on = 0;

    always #10 clk = ~clk;

    status_check_seq u_status_check_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cmd(req_cmd), .req_wdata(req_wdata), .busy(busy), .done(done),
        .result(result), .rd_data(rd_data), .status_word(status_word),
        .error_word(error_word), .log_word(log_word), .xf_start(xf_start),
        .xf_write(xf_write), .xf_cmd(xf_cmd), .xf_wdata(xf_wdata),
        .xf_done(xf_done), .xf_fail(xf_fail), .xf_rdata(xf_rdata)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Responder model: answers each launched transfer after LAT cycles.
    initial begin
        forever begin
            @(negedge clk);
            xf_done = 0; xf_fail = 0; xf_rdata = 64'h0;
            if (xf_start) begin
                if (nops < 8) begin
                    lc[nops] = xf_cmd; lw[nops] = xf_write; ld[nops] = xf_wdata;
                end
                repeat (LAT - 1) @(negedge clk);
                xf_done = 1;
                xf_fail = (nops == fail_at);
                if (xf_fail) xf_rdata = 64'hDEAD_BEEF_DEAD_BEEF;
                else if (nops == 0) xf_rdata = V_MAIN;
                else if (xf_cmd == C_STAT) xf_rdata = V_STAT | (64'(err_on) << 61);
                else if (xf_cmd == C_ERR) xf_rdata = V_ERR;
                else if (xf_cmd == C_LOG) xf_rdata = V_LOG;
                nops++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] ecmd [7];
        logic        ewr  [7];
        int exp_n, exp_res, wait_n;
        logic saw_done;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 reset busy", 64'(busy), 0);
        chk("R9 reset done", 64'(done), 0);
        chk("R10 reset xf_start", 64'(xf_start), 0);
        chk("R8 reset status_word", status_word, 0);
        for (int w = 0; w < 2; w++) begin
            for (int f = 0; f < 8; f++) begin
                for (int e = 0; e < 2; e++) begin
                    fail_at = f; err_on = e[0]; nops = 0;
                    req_valid = 1; req_write = w[0];
                    req_cmd = 32'h0000_1200 + 32'(f);
                    req_wdata = 64'h1234_5678_9ABC_DEF0 ^ 64'(f);
                    @(negedge clk);
                    req_valid = 0;
                    chk("R9 busy after accept", 64'(busy), 1);
                    chk("R8 cleared on accept", status_word | error_word | log_word | rd_data, 0);
                    @(negedge clk);
                    req_valid = 1; req_cmd = 32'h0000_0BAD;  // must be ignored
                    @(negedge clk);
                    req_valid = 0;
                    saw_done = 0; wait_n = 0;
                    while (!saw_done && wait_n < 200) begin
                        @(negedge clk);
                        saw_done = done; wait_n++;
                    end
                    exp_n = (f == 0) ? 1 : (f == 1) ? 2 : (e == 1) ? 7 : 2;
                    exp_res = (f <= 1) ? 1 : (e == 1) ? 2 : 0;
                    chk("R9 done seen", 64'(saw_done), 1);
                    chk("R9 busy low at done", 64'(busy), 0);
                    if (f <= 1) chk("R7 link result", 64'(result), 64'(exp_res));
                    else if (e == 1) chk("R6 remote result", 64'(result), 64'(exp_res));
                    else chk("R3 ok result", 64'(result), 64'(exp_res));
                    ecmd = '{32'h0000_1200 + 32'(f), C_STAT, C_ERR, C_LOG, C_STAT, C_ERR, C_LOG};
                    ewr  = '{w[0], 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
                    repeat (LAT + 2) @(negedge clk);
                    chk("R7 R3 transfer count", 64'(nops), 64'(exp_n));
                    chk("R1 first command", 64'(lc[0]), 64'(ecmd[0]));
                    chk("R1 first direction", 64'(lw[0]), 64'(ewr[0]));
                    if (w == 1) chk("R1 write data", ld[0], 64'h1234_5678_9ABC_DEF0 ^ 64'(f));
                    for (int i = 1; i < exp_n && i < 7; i++) begin
                        if (i == 1) chk("R2 status command", 64'(lc[i]), 64'(ecmd[i]));
                        else if (i < 4) chk("R4 diag command", 64'(lc[i]), 64'(ecmd[i]));
                        else chk("R5 clear command", 64'(lc[i]), 64'(ecmd[i]));
                        chk("R5 direction", 64'(lw[i]), 64'(ewr[i]));
                        if (i >= 4) chk("R5 zero data", ld[i], 0);
                    end
                    chk("R8 rd_data", rd_data, (w == 0 && f != 0) ? V_MAIN : 64'h0);
                    chk("R8 status_word", status_word,
                        (f >= 2) ? (V_STAT | (64'(e) << 61)) : 64'h0);
                    chk("R8 error_word", error_word,
                        (e == 1 && f >= 3) ? V_ERR : 64'h0);
                    chk("R8 log_word", log_word,
                        (e == 1 && f >= 2 && f != 3) ? V_LOG : 64'h0);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule